// File: doc/BRIEF.md
# DMA Burst Request Planner

This block turns one DMA buffer transfer into a sequence of bus-master burst requests. A job holds a word-aligned start byte address, a count of 32-bit beats and a direction flag. The job is offered on a valid/ready port. The block then presents one burst at a time on a second valid/ready port. Each burst carries a byte address, a beat count and an AHB burst type. After a burst is accepted, the block moves to the next one, and it pulses `done` once the whole buffer has been issued.

Several configuration pins shape the bursts: a transmit length field, a receive length field, a select that routes receive jobs to their own field, a times-four length multiplier, a fixed-burst mode and an address-aligned mode. The block samples them at the moment a job is accepted and holds them for that job. A burst never crosses a 1 KB address boundary. A length field that is not a power of two is reported on `cfg_err`, and that job is issued as single beats.

Back-pressure rules: `job_ready` is high only while no job is in progress, and a job is taken on a cycle where `job_valid` and `job_ready` are both high. `burst_valid` stays high from the cycle after the job is taken until the last burst is accepted. While `burst_ready` is low, `burst_addr`, `burst_len` and `burst_kind` hold their values.

Top module: `dma_burst_planner`

## Requirements
- R1: A job is taken on a rising edge with `job_valid` and `job_ready` both high. `job_ready` is low while bursts are pending. A pending burst holds its address, length and type unchanged while `burst_ready` is low.
- R2: Burst length selection depends on `cfg_sep_len` and `job_is_rx`. When both are high, the effective length comes from `cfg_rx_len`. In every other case it comes from `cfg_tx_len`.
- R3: With `cfg_x4` high, the effective length is four times the selected field, which gives 4 to 128 beats.
- R4: A selected field that is not one of 1, 2, 4, 8, 16 or 32 sets `cfg_err` from the cycle after the job is taken until the next job is taken. The beats of that job are issued as SINGLE bursts of length 1.
- R5: With fixed mode off, each burst is the shortest of three lengths: the effective length, the remaining beats and the beats left before the 1 KB boundary. A burst of length 1 has type SINGLE (code 3'b000). Any longer burst has type INCR (code 3'b001).
- R6: With fixed mode on, each burst is the largest of INCR16 (3'b111, 16 beats), INCR8 (3'b101, 8 beats) or INCR4 (3'b011, 4 beats) that does not exceed the effective length, the remaining beats or the distance to the boundary. If none of them fits, the burst is a SINGLE of one beat.
- R7: With fixed mode and aligned mode both on, every burst, including the first, starts at a word address that is a multiple of its own beat count.
- R8: With aligned mode on and fixed mode off, the first burst starts at the job address and is not trimmed for alignment. Every later burst is also cut so that it ends on a multiple of the effective length.
- R9: No burst crosses a 1 KB byte-address boundary. A burst that would cross one is shortened so that it ends at the boundary.
- R10: Each accepted burst advances the address by 4 bytes per beat. `done` is high for one cycle, the cycle after the last burst is accepted. A zero-beat job issues no burst and raises `done` in the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_valid | input | 1 | Job offered |
| job_ready | output | 1 | Block idle, job can be taken |
| job_addr | input | ADDR_W | Word-aligned start byte address |
| job_beats | input | CNT_W | Number of 32-bit beats in the buffer |
| job_is_rx | input | 1 | Job belongs to the receive direction |
| cfg_tx_len | input | PBL_W | Transmit (shared) burst length field |
| cfg_rx_len | input | PBL_W | Receive burst length field |
| cfg_x4 | input | 1 | Multiply the burst length by four |
| cfg_sep_len | input | 1 | Receive jobs use the receive length field |
| cfg_fixed | input | 1 | Fixed-length burst types only |
| cfg_aligned | input | 1 | Address-aligned bursts |
| burst_valid | output | 1 | Burst request pending |
| burst_ready | input | 1 | Burst request accepted |
| burst_addr | output | ADDR_W | Burst start byte address |
| burst_len | output | BOUND_LOG2-1 | Beats in this burst |
| burst_kind | output | 3 | AHB burst type code |
| done | output | 1 | One-cycle pulse when the buffer is complete |
| cfg_err | output | 1 | Selected length field was invalid for the current job |

## Verification
A job taken on a rising edge shows its first burst and its `cfg_err` value after that same edge, because one register stage lies between the job port and the burst port. Each later burst shows after the edge that accepts the previous one, and `done` shows after the edge that accepts the last burst. The bench drives inputs and samples outputs only at falling edges. It holds `burst_ready` high for exactly one rising edge per expected burst and checks the next burst, or `done`, at the following falling edge. The back-pressure case leaves `burst_ready` low for several edges and checks that the pending burst does not change.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  typedef enum logic [2:0] {
    HB_SINGLE = 3'b000,
    HB_INCR   = 3'b001,
    HB_INCR4  = 3'b011,
    HB_INCR8  = 3'b101,
    HB_INCR16 = 3'b111
  } hburst_e;
endpackage

// File: rtl/dbp_cfg_decode.sv
// Picks the length field for the job's direction, checks it and scales it.
module dbp_cfg_decode #(
  parameter int PBL_W = 6,
  localparam int EFF_W = PBL_W + 2
) (
  input  logic [PBL_W-1:0] tx_len,
  input  logic [PBL_W-1:0] rx_len,
  input  logic             is_rx,
  input  logic             sep_len,
  input  logic             x4,
  output logic [EFF_W-1:0] eff_len,
  output logic             bad_len
);
  logic [PBL_W-1:0] sel_len;

  always_comb begin
    sel_len = (sep_len && is_rx) ? rx_len : tx_len;
    bad_len = !$onehot(sel_len);
    if (bad_len)
      eff_len = EFF_W'(1);
    else if (x4)
      eff_len = EFF_W'(sel_len) << 2;
    else
      eff_len = EFF_W'(sel_len);
  end
endmodule

// File: rtl/dbp_size_pick.sv
// Combinational choice of the next burst's length and type.
module dbp_size_pick
  import dbp_pkg::*;
#(
  parameter int EFF_W  = 8,
  parameter int CNT_W  = 16,
  parameter int SPAN_W = 8,
  localparam int LEN_W = SPAN_W + 1,
  localparam int SPAN  = 1 << SPAN_W
) (
  input  logic [SPAN_W-1:0] wa_low,
  input  logic [CNT_W-1:0]  rem,
  input  logic [EFF_W-1:0]  eff,
  input  logic              fixed,
  input  logic              aligned,
  input  logic              first,
  output logic [LEN_W-1:0]  len,
  output hburst_e           kind
);
  logic [LEN_W-1:0] rem_c, to_bd, lim, eff_l, wa_l, al, s;

  always_comb begin
    eff_l = LEN_W'(eff);
    wa_l  = LEN_W'(wa_low);
    rem_c = (rem >= CNT_W'(SPAN)) ? LEN_W'(SPAN) : rem[LEN_W-1:0];
    to_bd = LEN_W'(SPAN) - wa_l;
    lim   = eff_l;
    if (rem_c < lim) lim = rem_c;
    if (to_bd < lim) lim = to_bd;
    al    = eff_l - (wa_l & (eff_l - LEN_W'(1)));
    s     = '0;
    len   = LEN_W'(1);
    kind  = HB_SINGLE;
    if (!fixed) begin
      if (aligned && !first && al < lim) lim = al;
      len  = lim;
      kind = (lim == LEN_W'(1)) ? HB_SINGLE : HB_INCR;
    end else begin
      for (int k = 2; k <= 4; k++) begin
        s = LEN_W'(1) << k;
        if (s <= lim && (!aligned || (wa_l & (s - LEN_W'(1))) == '0)) begin
          len  = s;
          kind = (k == 2) ? HB_INCR4 : (k == 3) ? HB_INCR8 : HB_INCR16;
        end
      end
    end
  end
endmodule

// File: rtl/dbp_walker.sv
// Holds the job state and steps through the buffer burst by burst.
module dbp_walker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int EFF_W  = 8,
  parameter int LEN_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              job_valid,
  output logic              job_ready,
  input  logic [ADDR_W-1:0] job_addr,
  input  logic [CNT_W-1:0]  job_beats,
  input  logic [EFF_W-1:0]  eff_in,
  input  logic              bad_in,
  input  logic              fixed_in,
  input  logic              aligned_in,
  input  logic              burst_ready,
  input  logic [LEN_W-1:0]  burst_len,
  output logic              busy,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  rem_q,
  output logic [EFF_W-1:0]  eff_q,
  output logic              fixed_q,
  output logic              aligned_q,
  output logic              first_q,
  output logic              err_q,
  output logic              done_q
);
  logic fire, last;

  assign job_ready = !busy;
  assign fire      = busy && burst_ready;
  assign last      = fire && (CNT_W'(burst_len) == rem_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      addr_q    <= '0;
      rem_q     <= '0;
      eff_q     <= '0;
      fixed_q   <= 1'b0;
      aligned_q <= 1'b0;
      first_q   <= 1'b0;
      err_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (job_valid && !busy) begin
        addr_q    <= job_addr;
        rem_q     <= job_beats;
        eff_q     <= eff_in;
        fixed_q   <= fixed_in;
        aligned_q <= aligned_in;
        first_q   <= 1'b1;
        err_q     <= bad_in;
        if (job_beats == '0) done_q <= 1'b1;
        else                 busy   <= 1'b1;
      end else if (fire) begin
        addr_q  <= addr_q + (ADDR_W'(burst_len) << 2);
        rem_q   <= rem_q - CNT_W'(burst_len);
        first_q <= 1'b0;
        if (last) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R1: a stalled burst keeps its position in the buffer
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !burst_ready |=> busy && $stable(addr_q) && $stable(rem_q));
  // R10: done only comes when no burst is pending
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);
  // R10: a burst never takes more beats than remain
  p_no_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (CNT_W'(burst_len) <= rem_q) && burst_len != '0);
endmodule

// File: rtl/dma_burst_planner.sv
module dma_burst_planner
  import dbp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int PBL_W      = 6,
  parameter int BOUND_LOG2 = 10,
  localparam int SPAN_W = BOUND_LOG2 - 2,
  localparam int SPAN   = 1 << SPAN_W,
  localparam int EFF_W  = PBL_W + 2,
  localparam int LEN_W  = SPAN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              job_valid,
  output logic              job_ready,
  input  logic [ADDR_W-1:0] job_addr,
  input  logic [CNT_W-1:0]  job_beats,
  input  logic              job_is_rx,
  input  logic [PBL_W-1:0]  cfg_tx_len,
  input  logic [PBL_W-1:0]  cfg_rx_len,
  input  logic              cfg_x4,
  input  logic              cfg_sep_len,
  input  logic              cfg_fixed,
  input  logic              cfg_aligned,
  output logic              burst_valid,
  input  logic              burst_ready,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [LEN_W-1:0]  burst_len,
  output logic [2:0]        burst_kind,
  output logic              done,
  output logic              cfg_err
);
  logic [EFF_W-1:0]  eff_in, eff_q;
  logic              bad_in, busy, fixed_q, aligned_q, first_q;
  logic [CNT_W-1:0]  rem_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len;
  hburst_e           kind;

  dbp_cfg_decode #(.PBL_W(PBL_W)) u_dec (
    .tx_len(cfg_tx_len), .rx_len(cfg_rx_len), .is_rx(job_is_rx),
    .sep_len(cfg_sep_len), .x4(cfg_x4), .eff_len(eff_in), .bad_len(bad_in)
  );

  dbp_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .EFF_W(EFF_W), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
    .job_addr(job_addr), .job_beats(job_beats), .eff_in(eff_in), .bad_in(bad_in),
    .fixed_in(cfg_fixed), .aligned_in(cfg_aligned), .burst_ready(burst_ready),
    .burst_len(len), .busy(busy), .addr_q(addr_q), .rem_q(rem_q), .eff_q(eff_q),
    .fixed_q(fixed_q), .aligned_q(aligned_q), .first_q(first_q), .err_q(cfg_err),
    .done_q(done)
  );

  dbp_size_pick #(.EFF_W(EFF_W), .CNT_W(CNT_W), .SPAN_W(SPAN_W)) u_pick (
    .wa_low(addr_q[SPAN_W+1:2]), .rem(rem_q), .eff(eff_q), .fixed(fixed_q),
    .aligned(aligned_q), .first(first_q), .len(len), .kind(kind)
  );

  assign burst_valid = busy;
  assign burst_addr  = addr_q;
  assign burst_len   = len;
  assign burst_kind  = kind;

  // R9: start offset plus length stays inside the 1 KB window
  p_no_cross_r9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> ({1'b0, LEN_W'(burst_addr[SPAN_W+1:2])} + {1'b0, burst_len})
                    <= (LEN_W+1)'(SPAN));
  // R6: fixed mode never emits an undefined-length burst
  p_fixed_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && fixed_q |-> burst_kind != HB_INCR);
  // R7: fixed plus aligned mode starts on a multiple of the burst size
  p_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && fixed_q && aligned_q |->
      (LEN_W'(burst_addr[SPAN_W+1:2]) & (burst_len - LEN_W'(1))) == '0);
  // R4: an invalid length field forces single beats
  p_err_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && cfg_err |-> burst_len == LEN_W'(1) && burst_kind == HB_SINGLE);
  // R5: no burst exceeds the effective length
  p_len_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> burst_len <= LEN_W'(eff_q));
  // R1: the job port is closed while bursts are pending
  p_busy_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> !job_ready);
endmodule

// File: tb/sim_dma_burst_planner.sv
`timescale 1ns/1ps
module sim_dma_burst_planner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        job_valid = 1'b0, job_is_rx = 1'b0;
  logic [31:0] job_addr = '0;
  logic [15:0] job_beats = '0;
  logic [5:0]  cfg_tx_len = 6'd1, cfg_rx_len = 6'd1;
  logic        cfg_x4 = 1'b0, cfg_sep_len = 1'b0, cfg_fixed = 1'b0, cfg_aligned = 1'b0;
  logic        burst_ready = 1'b0;
  logic        job_ready, burst_valid, done, cfg_err;
  logic [31:0] burst_addr;
  logic [8:0]  burst_len;
  logic [2:0]  burst_kind;
  int total = 0, fails = 0;

  localparam logic [2:0] K_SINGLE = 3'b000, K_INCR = 3'b001,
                         K_INCR4 = 3'b011, K_INCR8 = 3'b101, K_INCR16 = 3'b111;

  always #10 clk = ~clk;

  dma_burst_planner u0 (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
    .job_addr(job_addr), .job_beats(job_beats), .job_is_rx(job_is_rx),
    .cfg_tx_len(cfg_tx_len), .cfg_rx_len(cfg_rx_len), .cfg_x4(cfg_x4),
    .cfg_sep_len(cfg_sep_len), .cfg_fixed(cfg_fixed), .cfg_aligned(cfg_aligned),
    .burst_valid(burst_valid), .burst_ready(burst_ready), .burst_addr(burst_addr),
    .burst_len(burst_len), .burst_kind(burst_kind), .done(done), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int tx, input int rx, input bit x4, input bit sep,
                         input bit fx, input bit al);
    cfg_tx_len = 6'(tx); cfg_rx_len = 6'(rx); cfg_x4 = x4;
    cfg_sep_len = sep; cfg_fixed = fx; cfg_aligned = al;
  endtask

  // Offer a job at a falling edge; it is taken at the next rising edge.
  task automatic start_job(input int addr, input int beats, input bit rx, input string req);
    chk(job_ready == 1'b1, req, "job_ready before job", job_ready, 1);
    job_addr = 32'(addr); job_beats = 16'(beats); job_is_rx = rx; job_valid = 1'b1;
    @(negedge clk);
    job_valid = 1'b0;
  endtask

  task automatic expect_burst(input int addr, input int len, input logic [2:0] kind,
                              input string req);
    chk(burst_valid == 1'b1, req, "burst_valid", burst_valid, 1);
    chk(burst_addr == 32'(addr), req, "burst_addr", burst_addr, addr);
    chk(burst_len == 9'(len), req, "burst_len", burst_len, len);
    chk(burst_kind == kind, req, "burst_kind", burst_kind, kind);
    burst_ready = 1'b1;
    @(negedge clk);
    burst_ready = 1'b0;
  endtask

  task automatic expect_done(input string req);
    chk(done == 1'b1, req, "done pulse", done, 1);
    chk(burst_valid == 1'b0, req, "idle after done", burst_valid, 0);
    @(negedge clk);
    chk(done == 1'b0, req, "done one cycle", done, 0);
  endtask

  task automatic t_reset;
    chk(burst_valid == 1'b0, "R1", "reset burst_valid", burst_valid, 0);
    chk(job_ready == 1'b1, "R1", "reset job_ready", job_ready, 1);
    chk(done == 1'b0, "R10", "reset done", done, 0);
    chk(cfg_err == 1'b0, "R4", "reset cfg_err", cfg_err, 0);
  endtask

  task automatic t_plain_incr;   // R5 R10
    set_cfg(8, 1, 0, 0, 0, 0);
    start_job(32'h1000, 20, 0, "R5");
    expect_burst(32'h1000, 8, K_INCR, "R5");
    expect_burst(32'h1020, 8, K_INCR, "R10");
    expect_burst(32'h1040, 4, K_INCR, "R5");
    expect_done("R10");
  endtask

  task automatic t_sep_len;      // R2
    set_cfg(16, 4, 0, 1, 0, 0);
    start_job(0, 8, 1, "R2");
    expect_burst(32'h0, 4, K_INCR, "R2");
    expect_burst(32'h10, 4, K_INCR, "R2");
    expect_done("R2");
    set_cfg(16, 4, 0, 0, 0, 0);
    start_job(0, 16, 1, "R2");
    expect_burst(32'h0, 16, K_INCR, "R2");
    expect_done("R2");
  endtask

  task automatic t_x4;           // R3 R5
    set_cfg(2, 1, 1, 0, 0, 0);
    start_job(32'h200, 9, 0, "R3");
    expect_burst(32'h200, 8, K_INCR, "R3");
    expect_burst(32'h220, 1, K_SINGLE, "R5");
    expect_done("R3");
  endtask

  task automatic t_fixed;        // R6
    set_cfg(32, 1, 0, 0, 1, 0);
    start_job(0, 23, 0, "R6");
    expect_burst(32'h00, 16, K_INCR16, "R6");
    expect_burst(32'h40, 4, K_INCR4, "R6");
    expect_burst(32'h50, 1, K_SINGLE, "R6");
    expect_burst(32'h54, 1, K_SINGLE, "R6");
    expect_burst(32'h58, 1, K_SINGLE, "R6");
    expect_done("R6");
  endtask

  task automatic t_fixed_aligned; // R7
    set_cfg(16, 1, 0, 0, 1, 1);
    start_job(32'h8, 20, 0, "R7");
    expect_burst(32'h08, 1, K_SINGLE, "R7");
    expect_burst(32'h0C, 1, K_SINGLE, "R7");
    expect_burst(32'h10, 4, K_INCR4, "R7");
    expect_burst(32'h20, 8, K_INCR8, "R7");
    expect_burst(32'h40, 4, K_INCR4, "R7");
    expect_burst(32'h50, 1, K_SINGLE, "R7");
    expect_burst(32'h54, 1, K_SINGLE, "R7");
    expect_done("R7");
  endtask

  task automatic t_incr_aligned; // R8
    set_cfg(8, 1, 0, 0, 0, 1);
    start_job(32'hC, 20, 0, "R8");
    expect_burst(32'h0C, 8, K_INCR, "R8");
    expect_burst(32'h2C, 5, K_INCR, "R8");
    expect_burst(32'h40, 7, K_INCR, "R8");
    expect_done("R8");
  endtask

  task automatic t_boundary;     // R9
    set_cfg(16, 1, 0, 0, 0, 0);
    start_job(32'h3F0, 10, 0, "R9");
    expect_burst(32'h3F0, 4, K_INCR, "R9");
    expect_burst(32'h400, 6, K_INCR, "R9");
    expect_done("R9");
    set_cfg(16, 1, 0, 0, 1, 0);
    start_job(32'h3F8, 6, 0, "R9");
    expect_burst(32'h3F8, 1, K_SINGLE, "R9");
    expect_burst(32'h3FC, 1, K_SINGLE, "R9");
    expect_burst(32'h400, 4, K_INCR4, "R9");
    expect_done("R9");
  endtask

  task automatic t_bad_len;      // R4
    set_cfg(3, 1, 1, 0, 1, 0);
    start_job(0, 2, 0, "R4");
    chk(cfg_err == 1'b1, "R4", "cfg_err after bad job", cfg_err, 1);
    expect_burst(32'h0, 1, K_SINGLE, "R4");
    expect_burst(32'h4, 1, K_SINGLE, "R4");
    expect_done("R4");
    chk(cfg_err == 1'b1, "R4", "cfg_err held until next job", cfg_err, 1);
    set_cfg(4, 1, 0, 0, 0, 0);
    start_job(0, 4, 0, "R4");
    chk(cfg_err == 1'b0, "R4", "cfg_err cleared by good job", cfg_err, 0);
    expect_burst(32'h0, 4, K_INCR, "R4");
    expect_done("R4");
  endtask

  task automatic t_zero;         // R10
    set_cfg(8, 1, 0, 0, 0, 0);
    start_job(32'h100, 0, 0, "R10");
    chk(burst_valid == 1'b0, "R10", "no burst for zero beats", burst_valid, 0);
    expect_done("R10");
  endtask

  task automatic t_backpressure; // R1
    set_cfg(4, 1, 0, 0, 0, 0);
    start_job(32'h80, 8, 0, "R1");
    for (int i = 0; i < 3; i++) begin
      job_valid = 1'b1; job_addr = 32'h0; job_beats = 16'd1;
      @(negedge clk);
      chk(burst_addr == 32'h80, "R1", "addr held under stall", burst_addr, 32'h80);
      chk(burst_len == 9'd4, "R1", "len held under stall", burst_len, 4);
      chk(job_ready == 1'b0, "R1", "job_ready low while busy", job_ready, 0);
    end
    job_valid = 1'b0;
    expect_burst(32'h80, 4, K_INCR, "R1");
    expect_burst(32'h90, 4, K_INCR, "R1");
    expect_done("R1");
  endtask

  initial begin
    #(20ns * 100000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_incr();
    t_sep_len();
    t_x4();
    t_fixed();
    t_fixed_aligned();
    t_incr_aligned();
    t_boundary();
    t_bad_len();
    t_zero();
    t_backpressure();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule